// File: doc/BRIEF.md
# Half-Duplex Bus Collision Detector

This block watches over a serial transmitter that drives a shared single-wire or open-drain line. The transmitter's own output level and the level read back from the line are compared at a chosen sampling instant. Any disagreement is a collision, and a sticky interrupt flag is raised. The sampling instant comes from one of two one-cycle strobes. One marks each rising edge of the transfer clock. The other is an underflow pulse from an external timer. A select pin chooses between them.

The block also owns the transmit-enable bit. Software sets and clears this bit with pulses. As an option, the bit drops by itself once a collision has been flagged. A second option holds back a requested transmission until the received line falls, so the transmitter can line up with another station's start bit. The received line is asynchronous and passes through a two-stage synchronizer before any use. All control and status pins are plain levels or one-cycle pulses. No data stream crosses this block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `buscol_guard`

## Requirements
- R1: After reset, `col_irq`, `tx_en`, `start_pend` and `tx_start` are all 0.
- R2: With `samp_sel`=0, a collision is sampled in a cycle where `xfer_rise`=1. `col_irq` is 1 from the next cycle on. `tmr_uflow` has no effect in this mode.
- R3: With `samp_sel`=1, a collision is sampled in a cycle where `tmr_uflow`=1, and `xfer_rise` has no effect.
- R4: A strobe that sees `tx_line` equal to the synchronized receive level does not set `col_irq`.
- R5: Collisions are sampled only while `tx_en`=1 and `tx_active`=1.
- R6: `col_irq` stays 1 until a `col_clr` pulse clears it in the next cycle. A clear in the same cycle as a new collision leaves it at 1.
- R7: With `auto_clr_en`=1, `tx_en` goes to 0 one cycle after `col_irq` becomes 1. With `auto_clr_en`=0, a collision leaves `tx_en` unchanged.
- R8: `txen_set` makes `tx_en` 1 in the next cycle, and `txen_clr` makes it 0. When both are given together, the clear wins.
- R9: With `start_sync_en`=0 and `tx_en`=1, a `start_req` pulse gives a one-cycle `tx_start` in the next cycle.
- R10: With `start_sync_en`=1 and `tx_en`=1, a `start_req` sets `start_pend` in the next cycle. It stays set until the synchronized receive line falls. One cycle after that fall is detected (three cycles after `rx_pin` goes low), `tx_start` pulses for one cycle and `start_pend` returns to 0.
- R11: `rx_pin` passes through two flip-flops before the comparison. A strobe given in the cycle `rx_pin` changes, or in the cycle after, still compares against the old level.
- R12: While `tx_en`=0, `start_req` produces neither `tx_start` nor `start_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_line | input | 1 | Level the transmitter is driving |
| rx_pin | input | 1 | Asynchronous level read back from the bus |
| xfer_rise | input | 1 | One-cycle strobe at each transfer-clock rising edge |
| tmr_uflow | input | 1 | One-cycle timer underflow strobe |
| samp_sel | input | 1 | Sampling source: 0 transfer clock, 1 timer |
| auto_clr_en | input | 1 | Drop tx_en automatically on a collision |
| start_sync_en | input | 1 | Hold transmission start until the receive line falls |
| tx_active | input | 1 | Shifter is currently sending |
| txen_set | input | 1 | Software pulse that sets tx_en |
| txen_clr | input | 1 | Software pulse that clears tx_en |
| col_clr | input | 1 | Software pulse that clears col_irq |
| start_req | input | 1 | Shifter request to begin a frame |
| tx_en | output | 1 | Transmit-enable bit |
| col_irq | output | 1 | Sticky collision interrupt flag |
| start_pend | output | 1 | Start held, waiting for a receive-line fall |
| tx_start | output | 1 | One-cycle transmission start pulse |

## Verification
Each register stage sets its own latency, counted from the cycle an input is driven. A strobe or a software pulse shows up at `col_irq`, `tx_en`, `start_pend` or `tx_start` one cycle later. The automatic clear of `tx_en` lands two cycles after the colliding strobe. A change on `rx_pin` reaches the comparison two cycles later and reaches `tx_start` three cycles later. The driver records each expected value together with the cycle number at which it falls due. The monitor compares each one only on that cycle, between clock edges.

// File: rtl/buscol_pkg.sv
package buscol_pkg;
  typedef enum logic {
    SRC_XFER  = 1'b0,
    SRC_TIMER = 1'b1
  } samp_src_e;

  localparam logic LINE_IDLE = 1'b1;
endpackage

// File: rtl/buscol_rxsync.sv
module buscol_rxsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  output logic rx_s,
  output logic rx_fall
);
  import buscol_pkg::*;
  localparam int SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] sr;
  logic          prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= {SW{LINE_IDLE}};
      prev <= LINE_IDLE;
    end else begin
      sr   <= {sr[SW-2:0], rx_pin};
      prev <= sr[SW-1];
    end
  end

  assign rx_s    = sr[SW-1];
  assign rx_fall = prev & ~sr[SW-1];

  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fall |-> $past(rx_s)); // R11
endmodule

// File: rtl/buscol_detect.sv
module buscol_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_sel,
  input  logic xfer_rise,
  input  logic tmr_uflow,
  input  logic tx_line,
  input  logic rx_s,
  input  logic tx_en,
  input  logic tx_active,
  input  logic col_clr,
  output logic col_flag
);
  import buscol_pkg::*;

  logic strobe;
  logic hit;

  always_comb begin
    strobe = (samp_src_e'(samp_sel) == SRC_TIMER) ? tmr_uflow : xfer_rise;
    hit    = strobe & tx_en & tx_active & (tx_line ^ rx_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       col_flag <= 1'b0;
    else if (hit)     col_flag <= 1'b1;
    else if (col_clr) col_flag <= 1'b0;
  end

  AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_flag) |-> $past(tx_en && tx_active)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (col_flag && !col_clr) |=> col_flag); // R6
endmodule

// File: rtl/buscol_txctl.sv
module buscol_txctl (
  input  logic clk,
  input  logic rst_n,
  input  logic txen_set,
  input  logic txen_clr,
  input  logic auto_clr_en,
  input  logic col_flag,
  output logic tx_en
);
  logic drop;

  assign drop = txen_clr | (auto_clr_en & col_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_en <= 1'b0;
    else if (drop)     tx_en <= 1'b0;
    else if (txen_set) tx_en <= 1'b1;
  end

  AST_AUTO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_clr_en && col_flag) |=> !tx_en); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    txen_clr |=> !tx_en); // R8
endmodule

// File: rtl/buscol_startgate.sv
module buscol_startgate (
  input  logic clk,
  input  logic rst_n,
  input  logic start_sync_en,
  input  logic tx_en,
  input  logic start_req,
  input  logic rx_fall,
  output logic start_pend,
  output logic tx_start
);
  logic rel_sync;
  logic rel_direct;

  always_comb begin
    rel_sync   = start_sync_en & tx_en & start_pend & rx_fall;
    rel_direct = ~start_sync_en & tx_en & start_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pend <= 1'b0;
      tx_start   <= 1'b0;
    end else begin
      tx_start <= rel_sync | rel_direct;
      if (!start_sync_en || !tx_en) start_pend <= 1'b0;
      else if (rel_sync)            start_pend <= 1'b0;
      else if (start_req)           start_pend <= 1'b1;
    end
  end

  AST_NO_START_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_start); // R12
  AST_PEND_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pend && start_sync_en && tx_en && !rx_fall) |=> (start_pend && !tx_start)); // R10
endmodule

// File: rtl/buscol_guard.sv
module buscol_guard #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_line,
  input  logic rx_pin,
  input  logic xfer_rise,
  input  logic tmr_uflow,
  input  logic samp_sel,
  input  logic auto_clr_en,
  input  logic start_sync_en,
  input  logic tx_active,
  input  logic txen_set,
  input  logic txen_clr,
  input  logic col_clr,
  input  logic start_req,
  output logic tx_en,
  output logic col_irq,
  output logic start_pend,
  output logic tx_start
);
  logic rx_s;
  logic rx_fall;

  buscol_rxsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .rx_s(rx_s), .rx_fall(rx_fall)
  );

  buscol_detect u_det (
    .clk(clk), .rst_n(rst_n), .samp_sel(samp_sel), .xfer_rise(xfer_rise),
    .tmr_uflow(tmr_uflow), .tx_line(tx_line), .rx_s(rx_s), .tx_en(tx_en),
    .tx_active(tx_active), .col_clr(col_clr), .col_flag(col_irq)
  );

  buscol_txctl u_txen (
    .clk(clk), .rst_n(rst_n), .txen_set(txen_set), .txen_clr(txen_clr),
    .auto_clr_en(auto_clr_en), .col_flag(col_irq), .tx_en(tx_en)
  );

  buscol_startgate u_gate (
    .clk(clk), .rst_n(rst_n), .start_sync_en(start_sync_en), .tx_en(tx_en),
    .start_req(start_req), .rx_fall(rx_fall), .start_pend(start_pend),
    .tx_start(tx_start)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!col_irq && !tx_en && !start_pend && !tx_start)); // R1
endmodule

// File: tb/sim_buscol_guard.sv
module sim_buscol_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_line = 1'b1, rx_pin = 1'b1, xfer_rise = 1'b0, tmr_uflow = 1'b0;
  logic samp_sel = 1'b0, auto_clr_en = 1'b0, start_sync_en = 1'b0, tx_active = 1'b0;
  logic txen_set = 1'b0, txen_clr = 1'b0, col_clr = 1'b0, start_req = 1'b0;
  logic tx_en, col_irq, start_pend, tx_start;

  localparam int S_COL = 0, S_TXEN = 1, S_PEND = 2, S_START = 3;

  typedef struct {
    int    due;
    int    sig;
    logic  val;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  buscol_guard u0 (
    .clk(clk), .rst_n(rst_n), .tx_line(tx_line), .rx_pin(rx_pin),
    .xfer_rise(xfer_rise), .tmr_uflow(tmr_uflow), .samp_sel(samp_sel),
    .auto_clr_en(auto_clr_en), .start_sync_en(start_sync_en),
    .tx_active(tx_active), .txen_set(txen_set), .txen_clr(txen_clr),
    .col_clr(col_clr), .start_req(start_req), .tx_en(tx_en),
    .col_irq(col_irq), .start_pend(start_pend), .tx_start(tx_start)
  );

  function automatic logic actual(int sig);
    case (sig)
      S_COL:   return col_irq;
      S_TXEN:  return tx_en;
      S_PEND:  return start_pend;
      default: return tx_start;
    endcase
  endfunction

  task automatic expect_at(int dly, int sig, logic val, string req);
    exp_t e;
    e.due = cyc + dly; e.sig = sig; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each expected item in the cycle it falls due
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        checks++;
        if (actual(q[i].sig) !== q[i].val) begin
          errors++;
          $display("FAIL %s sig%0d cycle %0d: actual %b expected %b",
                   q[i].req, q[i].sig, cyc, actual(q[i].sig), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    expect_at(1, S_COL, 1'b0, "R1");
    expect_at(1, S_TXEN, 1'b0, "R1");
    expect_at(1, S_PEND, 1'b0, "R1");
    expect_at(1, S_START, 1'b0, "R1");
    step(2);

    // R8 set
    txen_set = 1'b1; expect_at(1, S_TXEN, 1'b1, "R8"); step(); txen_set = 1'b0;
    tx_active = 1'b1;

    // R2: transfer-clock source, mismatch
    samp_sel = 1'b0; tx_line = 1'b1; rx_pin = 1'b0; step(3);
    tmr_uflow = 1'b1; expect_at(1, S_COL, 1'b0, "R2"); step(); tmr_uflow = 1'b0;
    xfer_rise = 1'b1; expect_at(1, S_COL, 1'b1, "R2"); step(); xfer_rise = 1'b0;
    step(2);
    expect_at(1, S_COL, 1'b1, "R6");
    expect_at(1, S_TXEN, 1'b1, "R7");
    step();
    col_clr = 1'b1; expect_at(1, S_COL, 1'b0, "R6"); step(); col_clr = 1'b0;
    col_clr = 1'b1; xfer_rise = 1'b1; expect_at(1, S_COL, 1'b1, "R6"); step();
    col_clr = 1'b0; xfer_rise = 1'b0;
    col_clr = 1'b1; step(); col_clr = 1'b0;

    // R3: timer source
    samp_sel = 1'b1;
    xfer_rise = 1'b1; expect_at(1, S_COL, 1'b0, "R3"); step(); xfer_rise = 1'b0;
    tmr_uflow = 1'b1; expect_at(1, S_COL, 1'b1, "R3"); step(); tmr_uflow = 1'b0;
    col_clr = 1'b1; step(); col_clr = 1'b0;

    // R4: matching levels
    rx_pin = 1'b1; step(3);
    tmr_uflow = 1'b1; expect_at(1, S_COL, 1'b0, "R4"); step(); tmr_uflow = 1'b0;
    tx_line = 1'b0; rx_pin = 1'b0; step(3);
    tmr_uflow = 1'b1; expect_at(1, S_COL, 1'b0, "R4"); step(); tmr_uflow = 1'b0;

    // R11: two-stage synchronizer delay
    tx_line = 1'b1; rx_pin = 1'b1; step(3);
    rx_pin = 1'b0; tmr_uflow = 1'b1; expect_at(1, S_COL, 1'b0, "R11"); step();
    expect_at(1, S_COL, 1'b0, "R11"); step();
    expect_at(1, S_COL, 1'b1, "R11"); step(); tmr_uflow = 1'b0;
    col_clr = 1'b1; step(); col_clr = 1'b0;

    // R5: gated by tx_active and tx_en
    tx_active = 1'b0;
    tmr_uflow = 1'b1; expect_at(1, S_COL, 1'b0, "R5"); step(); tmr_uflow = 1'b0;
    tx_active = 1'b1;
    txen_set = 1'b1; txen_clr = 1'b1; expect_at(1, S_TXEN, 1'b0, "R8"); step();
    txen_set = 1'b0; txen_clr = 1'b0;
    tmr_uflow = 1'b1; expect_at(1, S_COL, 1'b0, "R5"); step(); tmr_uflow = 1'b0;

    // R7: auto clear
    txen_set = 1'b1; step(); txen_set = 1'b0;
    auto_clr_en = 1'b1;
    tmr_uflow = 1'b1;
    expect_at(1, S_COL, 1'b1, "R7");
    expect_at(1, S_TXEN, 1'b1, "R7");
    expect_at(2, S_TXEN, 1'b0, "R7");
    step(); tmr_uflow = 1'b0; step();
    col_clr = 1'b1; step(); col_clr = 1'b0; auto_clr_en = 1'b0;

    // R12: requests ignored while disabled
    rx_pin = 1'b1; step(3);
    start_req = 1'b1; expect_at(1, S_START, 1'b0, "R12"); step(); start_req = 1'b0;
    start_sync_en = 1'b1;
    start_req = 1'b1; expect_at(1, S_PEND, 1'b0, "R12"); step(); start_req = 1'b0;
    start_sync_en = 1'b0;

    // R9: direct start
    txen_set = 1'b1; step(); txen_set = 1'b0;
    start_req = 1'b1;
    expect_at(1, S_START, 1'b1, "R9");
    expect_at(2, S_START, 1'b0, "R9");
    step(); start_req = 1'b0; step(2);

    // R10: start held until receive line falls
    start_sync_en = 1'b1;
    start_req = 1'b1;
    expect_at(1, S_PEND, 1'b1, "R10");
    expect_at(1, S_START, 1'b0, "R10");
    step(); start_req = 1'b0; step(3);
    rx_pin = 1'b0;
    expect_at(2, S_PEND, 1'b1, "R10");
    expect_at(2, S_START, 1'b0, "R10");
    expect_at(3, S_START, 1'b1, "R10");
    expect_at(3, S_PEND, 1'b0, "R10");
    expect_at(4, S_START, 1'b0, "R10");
    step(6);

    if (q.size() != 0) begin
      errors++;
      $display("FAIL pending: actual %0d items left expected 0", q.size());
    end
    finish_run();
  end
endmodule